// File: doc/BRIEF.md
# Error-Correcting On-Chip SRAM Controller

This block sits in front of a 32-bit wide on-chip memory. Every word is held together with 7 check bits from a single-error-correcting, double-error-detecting code. Ordinary writes compute the check bits. Ordinary reads decode the stored word, fix any one flipped bit and report any two flipped bits as an error.

A read that needed a correction writes the repaired word and fresh check bits back to the same location. It then bumps a saturating correction counter. The counter can be read and cleared through a small control space.

A diagnostic mode lets software store check bits exactly as supplied, and read back the raw stored data and check bits with no correction applied. This makes it possible to inject faults and inspect what the memory really holds. The full 64 KB instance uses `DEPTH = 16384`. The default is smaller, and the depth is a parameter.

Top module: `sram_ecc_ctrl`

## Requirements
- R1: While and after reset, `req_ready` is 1, `rsp_ready` is 0 and the correction counter reads 0.
- R2: An ordinary write followed by an ordinary read of the same address returns the written data with `rsp_err` 0. A write or control access raises `rsp_ready` in the cycle after acceptance. A read raises it one cycle later.
- R3: With exactly one of the 39 stored bits flipped (data bits 0..31, then check bits 0..6), an ordinary read returns the originally written data with `rsp_err` 0.
- R4: With any two distinct stored bits flipped, an ordinary read sets `rsp_err` to 1. No write-back happens, so a later diagnostic read shows the same corrupted contents. The counter does not change.
- R5: After a corrected ordinary read, a diagnostic read of that address returns the original data and the original check bits.
- R6: Each corrected ordinary read raises the counter by one, up to a ceiling of 2^CNT_W-1 where it stays. A control read (`req_ctl`=1, `req_write`=0) returns the count zero-extended in `rsp_rdata`. A control write sets it to 0.
- R7: When an ordinary read corrects an error, `req_ready` is 0 in the cycle its response is presented, while the write-back occupies the array. Otherwise `req_ready` is 1 in that cycle.
- R8: A diagnostic write (`req_diag`=1) stores `req_wcheck` unchanged. A diagnostic read returns the raw stored data and check bits with `rsp_err` 0, and never corrects, writes back or counts.
- R9: The code is linear. The all-zero word has all-zero check bits, the check bits of a XOR b equal the XOR of their check bits, and each single-data-bit word has check bits of weight at least 2 that differ from every other such word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Access request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_diag | input | 1 | Diagnostic access: raw check bits in and out |
| req_ctl | input | 1 | Access targets the correction counter instead of memory |
| req_addr | input | $clog2(DEPTH) | Word address |
| req_wdata | input | 32 | Write data |
| req_wcheck | input | 7 | Check bits stored by a diagnostic write |
| req_ready | output | 1 | Request is accepted on this edge when high |
| rsp_ready | output | 1 | One-cycle pulse: access complete, response fields valid |
| rsp_rdata | output | 32 | Read data (corrected, raw, or counter value) |
| rsp_rcheck | output | 7 | Stored check bits as read |
| rsp_err | output | 1 | Uncorrectable error on an ordinary read |

## Verification
The hardest situations to reach from the ports are a stored word carrying a single or double bit fault, and the scrub slot that follows a correction. Ordinary writes always produce consistent check bits, so no ordinary access can create a fault. The bench first reads a word's raw contents through the diagnostic path and flips one or two of the 39 bits in software. It then writes the result back as a diagnostic write. It sweeps every single bit position and every pair of positions, and observes the repair by a later diagnostic read.

// File: rtl/sram_ecc_pkg.sv
`timescale 1ns/1ps
package sram_ecc_pkg;

    localparam int DATA_W = 32;
    localparam int HAM_W  = 6;
    localparam int CHK_W  = HAM_W + 1;
    localparam int CODE_W = DATA_W + CHK_W;

    typedef logic [DATA_W-1:0] data_t;
    typedef logic [CHK_W-1:0]  chk_t;
    typedef logic [HAM_W-1:0]  syn_t;

    typedef struct packed {
        data_t data;
        chk_t  chk;
    } word_t;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_DECODE = 2'd1,
        ST_SCRUB  = 2'd2
    } state_t;

    typedef struct packed {
        logic  diag;
        logic  single;
        logic  double_err;
    } dec_flags_t;

    // Codeword position (1-based) of data bit idx: positions that are not powers of two.
    function automatic syn_t data_pos(input int idx);
        int   seen;
        syn_t pos;
        seen = 0;
        pos  = '0;
        for (int p = 3; p < CODE_W; p++) begin
            if ((p & (p - 1)) != 0) begin
                if (seen == idx) pos = syn_t'(p);
                seen++;
            end
        end
        return pos;
    endfunction

    // Hamming part: XOR of the positions of all set data bits.
    function automatic syn_t hamming(input data_t d);
        syn_t h;
        h = '0;
        for (int i = 0; i < DATA_W; i++) begin
            if (d[i]) h ^= data_pos(i);
        end
        return h;
    endfunction

    function automatic chk_t make_check(input data_t d);
        syn_t h;
        h = hamming(d);
        return {(^d) ^ (^h), h};
    endfunction

endpackage

// File: rtl/ecc_encoder.sv
`timescale 1ns/1ps
module ecc_encoder
    import sram_ecc_pkg::*;
(
    input  data_t enc_data,
    output chk_t  enc_chk
);
    always_comb enc_chk = make_check(enc_data);
endmodule

// File: rtl/ecc_decoder.sv
`timescale 1ns/1ps
module ecc_decoder
    import sram_ecc_pkg::*;
(
    input  word_t raw,
    output data_t fixed,
    output logic  single,
    output logic  double_err
);
    syn_t              syn;
    logic              ovr;
    logic [DATA_W-1:0] hit;
    logic              syn_chk;

    always_comb begin
        syn     = hamming(raw.data) ^ raw.chk[HAM_W-1:0];
        ovr     = (^raw.data) ^ (^raw.chk);
        syn_chk = (syn == '0) || $onehot(syn);
    end

    for (genvar i = 0; i < DATA_W; i++) begin : g_hit
        localparam syn_t POS = data_pos(i);
        assign hit[i] = (syn == POS);
    end

    always_comb begin
        fixed      = raw.data ^ (hit & {DATA_W{ovr}});
        single     = ovr && (syn_chk || (|hit));
        double_err = (!ovr && syn != '0) || (ovr && !syn_chk && !(|hit));
    end
endmodule

// File: rtl/err_counter.sv
`timescale 1ns/1ps
module err_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             inc,
    input  logic             clr,
    output logic [CNT_W-1:0] cnt
);
    localparam logic [CNT_W-1:0] CMAX = {CNT_W{1'b1}};

    always_ff @(posedge clk) begin
        if (rst || clr)             cnt <= '0;
        else if (inc && cnt != CMAX) cnt <= cnt + 1'b1;
    end

    a_r6_sat_hold: assert property (@(posedge clk) disable iff (rst)
        (!clr && cnt == CMAX) |=> (cnt == CMAX));
    a_r6_single_step: assert property (@(posedge clk) disable iff (rst)
        !clr |=> (cnt == $past(cnt) || cnt == $past(cnt) + 1'b1));
    a_r6_clear: assert property (@(posedge clk) disable iff (rst)
        clr |=> (cnt == '0));
endmodule

// File: rtl/ecc_mem_array.sv
`timescale 1ns/1ps
module ecc_mem_array
    import sram_ecc_pkg::*;
#(
    parameter int DEPTH = 1024,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          en,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  word_t         wword,
    output word_t         rword
);
    word_t mem [DEPTH];

    always_ff @(posedge clk) begin
        if (en) begin
            if (we) mem[addr] <= wword;
            else    rword     <= mem[addr];
        end
    end
endmodule

// File: rtl/sram_ecc_ctrl.sv
`timescale 1ns/1ps
module sram_ecc_ctrl
    import sram_ecc_pkg::*;
#(
    parameter int DEPTH = 1024,
    parameter int CNT_W = 16,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          req_valid,
    input  logic          req_write,
    input  logic          req_diag,
    input  logic          req_ctl,
    input  logic [AW-1:0] req_addr,
    input  logic [31:0]   req_wdata,
    input  logic [6:0]    req_wcheck,
    output logic          req_ready,
    output logic          rsp_ready,
    output logic [31:0]   rsp_rdata,
    output logic [6:0]    rsp_rcheck,
    output logic          rsp_err
);
    state_t        state;
    logic [AW-1:0] addr_q;
    logic          diag_q;
    logic          accept;
    logic          mem_en, mem_we;
    logic [AW-1:0] mem_addr;
    word_t         mem_wword, mem_rword;
    data_t         enc_in, dec_fixed;
    chk_t          enc_out;
    logic          dec_single, dec_double;
    logic          cnt_inc, cnt_clr;
    logic [CNT_W-1:0] cnt;

    assign req_ready = (state == ST_IDLE);
    assign accept    = req_valid && req_ready;

    always_comb begin
        mem_en    = (accept && !req_ctl) || (state == ST_SCRUB);
        mem_we    = (accept && req_write && !req_ctl) || (state == ST_SCRUB);
        mem_addr  = (state == ST_SCRUB) ? addr_q : req_addr;
        enc_in    = (state == ST_SCRUB) ? dec_fixed : req_wdata;
        mem_wword.data = enc_in;
        mem_wword.chk  = (state != ST_SCRUB && req_diag) ? req_wcheck : enc_out;
        cnt_inc   = (state == ST_DECODE) && !diag_q && dec_single;
        cnt_clr   = accept && req_ctl && req_write;
    end

    ecc_encoder u_enc (.enc_data(enc_in), .enc_chk(enc_out));

    ecc_decoder u_dec (
        .raw(mem_rword), .fixed(dec_fixed),
        .single(dec_single), .double_err(dec_double)
    );

    ecc_mem_array #(.DEPTH(DEPTH)) u_mem (
        .clk(clk), .en(mem_en), .we(mem_we), .addr(mem_addr),
        .wword(mem_wword), .rword(mem_rword)
    );

    err_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst(rst), .inc(cnt_inc), .clr(cnt_clr), .cnt(cnt)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= ST_IDLE;
            addr_q     <= '0;
            diag_q     <= 1'b0;
            rsp_ready  <= 1'b0;
            rsp_rdata  <= '0;
            rsp_rcheck <= '0;
            rsp_err    <= 1'b0;
        end else begin
            rsp_ready <= 1'b0;
            rsp_err   <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (accept) begin
                        addr_q <= req_addr;
                        diag_q <= req_diag;
                        if (req_ctl) begin
                            rsp_ready  <= 1'b1;
                            rsp_rdata  <= req_write ? '0 : 32'(cnt);
                            rsp_rcheck <= '0;
                        end else if (req_write) begin
                            rsp_ready <= 1'b1;
                        end else begin
                            state <= ST_DECODE;
                        end
                    end
                end
                ST_DECODE: begin
                    rsp_ready  <= 1'b1;
                    rsp_rdata  <= diag_q ? mem_rword.data : dec_fixed;
                    rsp_rcheck <= mem_rword.chk;
                    rsp_err    <= !diag_q && dec_double;
                    state      <= (!diag_q && dec_single) ? ST_SCRUB : ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    a_r4_scrub_follows: assert property (@(posedge clk) disable iff (rst)
        (state == ST_DECODE && !diag_q && dec_single) |=> (state == ST_SCRUB && mem_we));
    a_r4_no_scrub_on_double: assert property (@(posedge clk) disable iff (rst)
        (state == ST_DECODE && dec_double) |=> (state == ST_IDLE));
    a_r8_diag_no_scrub: assert property (@(posedge clk) disable iff (rst)
        (state == ST_DECODE && diag_q) |=> (state == ST_IDLE));
    a_r7_busy_in_scrub: assert property (@(posedge clk) disable iff (rst)
        (state == ST_SCRUB) |-> !req_ready);
    a_r3_flags_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(dec_single && dec_double));
    a_r4_err_with_rsp: assert property (@(posedge clk) disable iff (rst)
        rsp_err |-> rsp_ready);
endmodule

// File: tb/tb_sram_ecc_ctrl.sv
`timescale 1ns/1ps
module tb_sram_ecc_ctrl;
    localparam int DEPTH = 16;
    localparam int CNT_W = 4;
    localparam int AW    = 4;
    localparam int CMAX  = 15;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic req_valid = 0, req_write = 0, req_diag = 0, req_ctl = 0;
    logic [AW-1:0] req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic [6:0]  req_wcheck = '0;
    logic req_ready, rsp_ready, rsp_err;
    logic [31:0] rsp_rdata;
    logic [6:0]  rsp_rcheck;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    always #4 clk = ~clk;

    sram_ecc_ctrl #(.DEPTH(DEPTH), .CNT_W(CNT_W)) dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
        .req_diag(req_diag), .req_ctl(req_ctl), .req_addr(req_addr),
        .req_wdata(req_wdata), .req_wcheck(req_wcheck), .req_ready(req_ready),
        .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata), .rsp_rcheck(rsp_rcheck),
        .rsp_err(rsp_err)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Results of the last access
    logic [31:0] r_data;
    logic [6:0]  r_chk;
    logic        r_err;
    int          r_lat;
    logic        r_rdy;

    task automatic access(input bit wr, input bit dg, input bit ct,
                          input logic [AW-1:0] a, input logic [31:0] d, input logic [6:0] c);
        int guard;
        guard = 0;
        while (!req_ready && guard < 50) begin @(negedge clk); guard++; end
        req_valid = 1; req_write = wr; req_diag = dg; req_ctl = ct;
        req_addr = a; req_wdata = d; req_wcheck = c;
        @(posedge clk);
        @(negedge clk);
        req_valid = 0;
        r_lat = 0;
        while (!rsp_ready && guard < 50) begin @(negedge clk); r_lat++; guard++; end
        if (guard >= 50) check(1'b0, "R2", "handshake timeout", 64'(guard), 64'd0);
        r_data = rsp_rdata; r_chk = rsp_rcheck; r_err = rsp_err; r_rdy = req_ready;
    endtask

    function automatic logic [31:0] pattern(input int k);
        return (32'(k) * 32'h9E37_79B9) ^ 32'hA5C3_0F1E;
    endfunction

    task automatic flip(inout logic [31:0] d, inout logic [6:0] c, input int b);
        if (b < 32) d[b] = ~d[b];
        else        c[b-32] = ~c[b-32];
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    logic [6:0] unit_chk [32];

    initial begin
        logic [31:0] d0, dc, da, db;
        logic [6:0]  c0, cc, ca, cb;
        int expc;

        repeat (3) @(negedge clk);
        check(req_ready === 1'b1, "R1", "req_ready in reset", 64'(req_ready), 64'd1);
        check(rsp_ready === 1'b0, "R1", "rsp_ready in reset", 64'(rsp_ready), 64'd0);
        rst = 0;
        @(negedge clk);
        check(req_ready === 1'b1 && rsp_ready === 1'b0, "R1", "idle after reset",
              64'({req_ready, rsp_ready}), 64'b10);
        access(0, 0, 1, '0, '0, '0);
        check(r_data == 32'd0, "R1", "counter after reset", 64'(r_data), 64'd0);
        check(r_lat == 0, "R2", "control latency", 64'(r_lat), 64'd0);

        // R2: write/read sweep over every address
        for (int a = 0; a < DEPTH; a++) begin
            access(1, 0, 0, AW'(a), pattern(a), '0);
            check(r_lat == 0, "R2", "write latency", 64'(r_lat), 64'd0);
        end
        for (int a = 0; a < DEPTH; a++) begin
            access(0, 0, 0, AW'(a), '0, '0);
            check(r_data == pattern(a) && !r_err, "R2", "read data", 64'(r_data), 64'(pattern(a)));
            check(r_lat == 1 && r_rdy, "R2", "read latency/ready", 64'(r_lat), 64'd1);
        end

        // R9: code properties via ordinary write + diagnostic read
        access(1, 0, 0, 4'd1, 32'd0, '0);
        access(0, 1, 0, 4'd1, '0, '0);
        check(r_chk == 7'd0 && r_data == 32'd0, "R9", "zero word check", 64'(r_chk), 64'd0);
        for (int i = 0; i < 32; i++) begin
            access(1, 0, 0, 4'd2, 32'd1 << i, '0);
            access(0, 1, 0, 4'd2, '0, '0);
            unit_chk[i] = r_chk;
            check($countones(r_chk) >= 2, "R9", "unit weight", 64'(r_chk), 64'd3);
        end
        for (int i = 0; i < 32; i++) begin
            bit uniq;
            uniq = 1;
            for (int j = 0; j < 32; j++) if (j != i && unit_chk[j] == unit_chk[i]) uniq = 0;
            check(uniq, "R9", "unit distinct", 64'(unit_chk[i]), 64'(i));
        end
        for (int k = 0; k < 8; k++) begin
            da = pattern(k + 40); db = pattern(k + 90);
            access(1, 0, 0, 4'd3, da, '0); access(0, 1, 0, 4'd3, '0, '0); ca = r_chk;
            access(1, 0, 0, 4'd3, db, '0); access(0, 1, 0, 4'd3, '0, '0); cb = r_chk;
            access(1, 0, 0, 4'd3, da ^ db, '0); access(0, 1, 0, 4'd3, '0, '0);
            check(r_chk == (ca ^ cb), "R9", "linearity", 64'(r_chk), 64'(ca ^ cb));
        end

        // R3/R5/R6/R7: single-bit sweep over all 39 positions
        access(1, 0, 1, '0, '0, '0);
        access(0, 0, 1, '0, '0, '0);
        check(r_data == 32'd0, "R6", "counter cleared", 64'(r_data), 64'd0);
        expc = 0;
        for (int b = 0; b < 39; b++) begin
            logic [AW-1:0] a;
            a = AW'(b % DEPTH);
            access(1, 0, 0, a, pattern(b + 7), '0);
            access(0, 1, 0, a, '0, '0);
            d0 = r_data; c0 = r_chk; dc = d0; cc = c0;
            flip(dc, cc, b);
            access(1, 1, 0, a, dc, cc);
            access(0, 0, 0, a, '0, '0);
            check(r_data == d0 && !r_err, "R3", "single corrected", 64'(r_data), 64'(d0));
            check(r_rdy == 1'b0, "R7", "ready low during scrub", 64'(r_rdy), 64'd0);
            if (expc < CMAX) expc++;
            access(0, 0, 1, '0, '0, '0);
            check(r_data == 32'(expc), "R6", "counter value", 64'(r_data), 64'(expc));
            access(0, 1, 0, a, '0, '0);
            check(r_data == d0 && r_chk == c0, "R5", "scrubbed contents",
                  64'({r_data, 1'b0, r_chk}), 64'({d0, 1'b0, c0}));
            access(0, 0, 0, a, '0, '0);
            check(r_rdy == 1'b1 && !r_err, "R7", "ready after clean read", 64'(r_rdy), 64'd1);
        end

        // R8: diagnostic write/read of a corrupted word: raw, no scrub, no count
        access(1, 0, 1, '0, '0, '0);
        access(1, 0, 0, 4'd5, 32'hDEAD_BEEF, '0);
        access(0, 1, 0, 4'd5, '0, '0);
        d0 = r_data; c0 = r_chk; dc = d0; cc = c0;
        flip(dc, cc, 5);
        flip(dc, cc, 34);
        access(1, 1, 0, 4'd5, dc, cc);
        access(0, 1, 0, 4'd5, '0, '0);
        check(r_data == dc && r_chk == cc && !r_err, "R8", "raw diag read",
              64'({r_data, 1'b0, r_chk}), 64'({dc, 1'b0, cc}));
        dc = d0; cc = c0; flip(dc, cc, 9);
        access(1, 1, 0, 4'd5, dc, cc);
        access(0, 1, 0, 4'd5, '0, '0);
        check(r_data == dc && r_rdy == 1'b1, "R8", "diag single not fixed", 64'(r_data), 64'(dc));
        access(0, 1, 0, 4'd5, '0, '0);
        check(r_data == dc && r_chk == cc, "R8", "no write-back", 64'(r_data), 64'(dc));
        access(0, 0, 1, '0, '0, '0);
        check(r_data == 32'd0, "R8", "diag not counted", 64'(r_data), 64'd0);

        // R4: every pair of distinct bit positions
        for (int i = 0; i < 39; i++) begin
            for (int j = i + 1; j < 39; j++) begin
                logic [AW-1:0] a;
                a = AW'((i + j) % DEPTH);
                access(1, 0, 0, a, pattern(i * 39 + j), '0);
                access(0, 1, 0, a, '0, '0);
                dc = r_data; cc = r_chk;
                flip(dc, cc, i);
                flip(dc, cc, j);
                access(1, 1, 0, a, dc, cc);
                access(0, 0, 0, a, '0, '0);
                check(r_err == 1'b1 && r_rdy == 1'b1, "R4", "double detected",
                      64'({r_err, r_rdy}), 64'b11);
                access(0, 1, 0, a, '0, '0);
                check(r_data == dc && r_chk == cc, "R4", "double not written back",
                      64'({r_data, 1'b0, r_chk}), 64'({dc, 1'b0, cc}));
            end
        end
        access(0, 0, 1, '0, '0, '0);
        check(r_data == 32'd0, "R4", "doubles not counted", 64'(r_data), 64'd0);

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule